// File: doc/BRIEF.md
# Pipelined Burst Memory with Strobe-Driven Access Control

This block is a single-port synchronous memory with burst access. Each word is 36 bits wide and is split into four 9-bit lanes. Each lane holds eight data bits and one parity bit. The depth is set by a parameter. A burst starts when one of two active-low address strobes loads an external address. After that, a 2-bit offset counter steps through the four words of the aligned group, either in exclusive-or order or in ascending order with wraparound. An active-low advance input controls the stepping. Writes complete in the cycle they are presented and can be masked per lane. Reads return data one clock later through an output register.

The two strobes behave differently. The processor-side strobe always starts a read, and write enables are ignored in its load cycle. It is also ignored while the primary chip enable is inactive. The controller-side strobe starts a read or a write, chosen by the write enables it sees in its own cycle. The three chip enables are sampled only when an address is loaded. An output-drive flag turns off on deselect, stays off for the first selected cycle after a deselected period, and turns off during sleep.

Top module: `burst_sram_ctrl`

## Requirements
- R1: With `strb_cpu_n` low and `ce_n` low, a new address is loaded and a read starts. All write enables are ignored in that cycle.
- R2: In the cycle after a processor-strobe load, if no strobe is taken and `adv_n` is high, an active write goes to the loaded address.
- R3: While `ce_n` is high, `strb_cpu_n` has no effect. Without a controller strobe, that cycle acts as a continue or suspend cycle.
- R4: A controller strobe (`strb_ctl_n` low, no processor load) loads `addr_i`. It writes in the same cycle if a write is active, and otherwise reads.
- R5: The chip enables are sampled only on a load. If `ce_n` is high, `ce2_n` is high or `ce3` is low on a load, the block is deselected and `drive_o` is low after that edge. It stays low until a load with all enables active.
- R6: A write is active when `gw_n` is low, which writes all four lanes, or when `bw_en_n` is low and at least one `lane_n` bit is low. During a write, `drive_o` is low after the edge.
- R7: Bit i of `lane_n` guards word bits [9i+8:9i]. Any of the 16 lane patterns writes exactly the selected lanes and leaves the others unchanged.
- R8: Read data appears on `rdata_o`, with `drive_o` high, one clock after the read edge. A suspend cycle (`adv_n` high) returns the current word again. An advance cycle (`adv_n` low) returns the next burst word.
- R9: After reset or any deselected period, the first read after selection is not driven. Data is driven from the second selected read cycle on.
- R10: While `sleep_i` is high, every input is ignored, memory contents are kept, and `drive_o` is low after the edge. After release, nothing is accessed until a strobe loads an address.
- R11: With `lin_mode_i` low, the k-th word offset is start XOR k. With `lin_mode_i` high, it is (start + k) mod 4. The upper address bits are fixed for the whole burst.
- R12: If both strobes are low and `ce_n` is low, the processor strobe wins: a read, with no write.
- R13: After reset, `drive_o` is low and `rdata_o` is zero. `rdata_o` is zero whenever `drive_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | AW | External word address |
| strb_cpu_n | input | 1 | Processor-side address strobe, active low |
| strb_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_n | input | 1 | Primary chip enable, active low, also gates the processor strobe |
| ce2_n | input | 1 | Secondary chip enable, active low |
| ce3 | input | 1 | Tertiary chip enable, active high |
| gw_n | input | 1 | Global write, active low |
| bw_en_n | input | 1 | Byte-write enable, active low |
| lane_n | input | 4 | Per-lane write enables, active low |
| wdata_i | input | 36 | Write data, four 9-bit lanes |
| lin_mode_i | input | 1 | Burst order: 1 ascending, 0 exclusive-or |
| sleep_i | input | 1 | Sleep request, active high |
| rdata_o | output | 36 | Registered read data, zero when not driven |
| drive_o | output | 1 | Output-drive / data-valid flag |

## Verification
The sharpest collisions are a processor strobe and a controller strobe in the same cycle, and a load that is also a write. The bench drives both strobes low together with global write asserted. It then reads that address back, expecting the earlier contents, which shows the processor read won and no write took place. Sleep is raised in cycles that also carry strobes and writes, and it also lands in the middle of a burst. After release, the bench checks that an advance without a strobe stays undriven and that the stored words are unchanged. Seeded random traffic mixes all of these cases, and every cycle is compared against a bench model.

// File: rtl/bsram_pkg.sv
`timescale 1ns/1ps
package bsram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  typedef logic [1:0]       boff_t;
  typedef logic [LANES-1:0] lmask_t;

  // offset of the k-th burst word relative to a 2-bit start
  function automatic boff_t burst_offset(input boff_t start, input boff_t k, input logic lin);
    return lin ? boff_t'(start + k) : (start ^ k);
  endfunction

  // lanes written by this cycle's write enables (zero = no write)
  function automatic lmask_t lane_select(input logic gw_n, input logic bw_en_n, input lmask_t lane_n);
    if (!gw_n)         return '1;
    else if (!bw_en_n) return ~lane_n;
    else               return '0;
  endfunction
endpackage

// File: rtl/bsram_decode.sv
`timescale 1ns/1ps
module bsram_decode
  import bsram_pkg::*;
(
  input  logic   strb_cpu_n,
  input  logic   strb_ctl_n,
  input  logic   adv_n,
  input  logic   ce_n,
  input  logic   ce2_n,
  input  logic   ce3,
  input  logic   gw_n,
  input  logic   bw_en_n,
  input  lmask_t lane_n,
  input  logic   sleep_i,
  input  logic   sel_q,
  output logic   load_cpu,
  output logic   load_any,
  output logic   load_ok,
  output logic   step,
  output logic   do_read,
  output logic   do_write,
  output lmask_t wmask,
  output logic   sel_d
);
  logic wr_act;
  logic cpu_hit;
  logic ctl_hit;

  always_comb begin
    wmask    = lane_select(gw_n, bw_en_n, lane_n);
    wr_act   = |wmask;
    cpu_hit  = !strb_cpu_n && !ce_n;
    ctl_hit  = !strb_ctl_n && !cpu_hit;
    load_cpu = !sleep_i && cpu_hit;
    load_any = !sleep_i && (cpu_hit || ctl_hit);
    load_ok  = !ce_n && !ce2_n && ce3;
    step     = 1'b0;
    do_read  = 1'b0;
    do_write = 1'b0;
    sel_d    = sel_q;
    if (sleep_i) begin
      sel_d = 1'b0;
    end else if (load_any) begin
      sel_d    = load_ok;
      do_read  = load_ok && (load_cpu || !wr_act);
      do_write = load_ok && !load_cpu && wr_act;
    end else if (sel_q) begin
      step     = !adv_n;
      do_read  = !wr_act;
      do_write = wr_act;
    end
  end
endmodule

// File: rtl/bsram_burst_addr.sv
`timescale 1ns/1ps
module bsram_burst_addr
  import bsram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic          load,
  input  logic          step,
  input  logic          lin,
  output logic [AW-1:0] eff_addr
);
  localparam int HW = AW - 2;

  logic [HW-1:0] base_q;
  boff_t         start_q;
  boff_t         cnt_q;
  boff_t         cnt_d;

  always_comb begin
    cnt_d = step ? boff_t'(cnt_q + 2'd1) : cnt_q;
    if (load) eff_addr = addr_i;
    else      eff_addr = {base_q, burst_offset(start_q, cnt_d, lin)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      start_q <= '0;
      cnt_q   <= '0;
    end else if (load) begin
      base_q  <= addr_i[AW-1:2];
      start_q <= addr_i[1:0];
      cnt_q   <= '0;
    end else begin
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/bsram_lane_mem.sv
`timescale 1ns/1ps
module bsram_lane_mem
  import bsram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic              we,
  input  lmask_t            wmask,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic              drive_d,
  output logic [WORD_W-1:0] rdata_o,
  output logic              drive_o
);
  localparam int DEPTH = 1 << AW;

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [WORD_W-1:0] rd_q;
  logic              drv_q;

  always_ff @(posedge clk) begin
    if (we) begin
      for (int l = 0; l < LANES; l++) begin
        if (wmask[l]) mem_q[addr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      drv_q <= 1'b0;
    end else begin
      if (re) rd_q <= mem_q[addr];
      drv_q <= drive_d;
    end
  end

  assign drive_o = drv_q;
  assign rdata_o = drv_q ? rd_q : '0;
endmodule

// File: rtl/burst_sram_ctrl.sv
`timescale 1ns/1ps
module burst_sram_ctrl
  import bsram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr_i,
  input  logic              strb_cpu_n,
  input  logic              strb_ctl_n,
  input  logic              adv_n,
  input  logic              ce_n,
  input  logic              ce2_n,
  input  logic              ce3,
  input  logic              gw_n,
  input  logic              bw_en_n,
  input  logic [3:0]        lane_n,
  input  logic [35:0]       wdata_i,
  input  logic              lin_mode_i,
  input  logic              sleep_i,
  output logic [35:0]       rdata_o,
  output logic              drive_o
);
  logic          sel_q;
  logic          sel_d;
  logic          load_cpu_w;
  logic          load_w;
  logic          load_ok_w;
  logic          step_w;
  logic          rd_w;
  logic          we_w;
  lmask_t        wmask_w;
  logic [AW-1:0] eff_addr_w;
  logic          drive_d_w;

  bsram_decode u_dec (
    .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
    .ce_n(ce_n), .ce2_n(ce2_n), .ce3(ce3),
    .gw_n(gw_n), .bw_en_n(bw_en_n), .lane_n(lane_n),
    .sleep_i(sleep_i), .sel_q(sel_q),
    .load_cpu(load_cpu_w), .load_any(load_w), .load_ok(load_ok_w),
    .step(step_w), .do_read(rd_w), .do_write(we_w),
    .wmask(wmask_w), .sel_d(sel_d)
  );

  bsram_burst_addr #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
    .load(load_w), .step(step_w), .lin(lin_mode_i),
    .eff_addr(eff_addr_w)
  );

  // output-enable delay: a read drives only if the block was selected before this edge
  assign drive_d_w = rd_w && sel_q;

  bsram_lane_mem #(.AW(AW)) u_mem (
    .clk(clk), .rst_n(rst_n), .addr(eff_addr_w),
    .we(we_w), .wmask(wmask_w), .wdata(wdata_i),
    .re(rd_w), .drive_d(drive_d_w),
    .rdata_o(rdata_o), .drive_o(drive_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= sel_d;
  end
endmodule

// File: rtl/bsram_chk.sv
`timescale 1ns/1ps
module bsram_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sleep_i,
  input logic        adv_n,
  input logic        load_w,
  input logic        load_ok_w,
  input logic        load_cpu_w,
  input logic        we_w,
  input logic        rd_w,
  input logic        sel_q,
  input logic        drive_o,
  input logic [35:0] rdata_o
);
  assert_cpu_load_no_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load_cpu_w |-> !we_w);
  assert_deselect_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_w && !load_ok_w) |=> !drive_o);
  assert_write_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    we_w |=> !drive_o);
  assert_suspend_repeat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_o && !load_w && sel_q && adv_n && rd_w && !sleep_i) |=> (drive_o && $stable(rdata_o)));
  assert_reselect_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (load_w && !sel_q) |=> !drive_o);
  assert_sleep_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |=> !drive_o);
  assert_zero_when_off_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_o |-> (rdata_o == 36'd0));
endmodule

bind burst_sram_ctrl bsram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .adv_n(adv_n),
  .load_w(load_w), .load_ok_w(load_ok_w), .load_cpu_w(load_cpu_w),
  .we_w(we_w), .rd_w(rd_w), .sel_q(sel_q),
  .drive_o(drive_o), .rdata_o(rdata_o)
);

// File: tb/burst_sram_ctrl_tb.sv
`timescale 1ns/1ps
module burst_sram_ctrl_tb;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic strb_cpu_n = 1'b1, strb_ctl_n = 1'b1, adv_n = 1'b1;
  logic ce_n = 1'b0, ce2_n = 1'b0, ce3 = 1'b1;
  logic gw_n = 1'b1, bw_en_n = 1'b1;
  logic [3:0] lane_n = 4'hF;
  logic [35:0] wdata_i = '0;
  logic lin_mode_i = 1'b0, sleep_i = 1'b0;
  logic [35:0] rdata_o;
  logic drive_o;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [35:0] m_mem [DEPTH];
  bit          m_sel = 0, m_drv = 0;
  logic [35:0] m_rd = '0;
  logic [AW-3:0] m_base = '0;
  logic [1:0]  m_start = '0, m_k = '0;

  always #5 clk = ~clk;

  burst_sram_ctrl #(.AW(AW)) u_dut (.*);

  function automatic logic [1:0] ofs(input logic [1:0] s, input logic [1:0] k, input bit lin);
    logic [2:0] sum;
    sum = {1'b0, s} + {1'b0, k};
    if (lin) return sum[1:0];
    return {s[1] != k[1], s[0] != k[0]};
  endfunction

  function automatic logic [35:0] word_of(input int a);
    return {a[7:0], 4'h5, a[7:0], 8'hA3, a[7:0]} ^ 36'h9_1234_5678;
  endfunction

  task automatic model_step();
    bit cpu, ctl, rd, wr, prev;
    logic [3:0] wm;
    logic [AW-1:0] a;
    if (sleep_i) begin
      m_sel = 0; m_drv = 0; return;
    end
    cpu = (strb_cpu_n == 0) && (ce_n == 0);
    ctl = (strb_ctl_n == 0) && !cpu;
    if (gw_n == 0) wm = 4'b1111;
    else if (bw_en_n == 0) wm = ~lane_n;
    else wm = 4'b0000;
    rd = 0; wr = 0; prev = m_sel; a = '0;
    if (cpu || ctl) begin
      m_sel = (ce_n == 0) && (ce2_n == 0) && (ce3 == 1);
      a = addr_i; m_base = addr_i[AW-1:2]; m_start = addr_i[1:0]; m_k = 0;
      rd = m_sel && (cpu || wm == 0);
      wr = m_sel && !cpu && wm != 0;
    end else if (m_sel) begin
      if (adv_n == 0) m_k = m_k + 2'd1;
      a = {m_base, ofs(m_start, m_k, lin_mode_i)};
      rd = (wm == 0); wr = (wm != 0);
    end
    if (wr) for (int l = 0; l < 4; l++) if (wm[l]) m_mem[a][l*9 +: 9] = wdata_i[l*9 +: 9];
    if (rd) m_rd = m_mem[a];
    m_drv = rd && prev;
  endtask

  task automatic check(input string tag);
    logic [35:0] exp_d;
    exp_d = m_drv ? m_rd : 36'd0;
    checks++;
    if (drive_o !== m_drv || rdata_o !== exp_d) begin
      fails++;
      $display("FAIL %s: drive=%0b data=%h expected drive=%0b data=%h", tag, drive_o, rdata_o, m_drv, exp_d);
    end
  endtask

  task automatic cyc(input string tag, input bit pn, input bit cn, input bit an,
                     input bit c1n, input bit c2n, input bit c3, input bit gwn,
                     input bit bwn, input logic [3:0] ln, input logic [35:0] wd,
                     input logic [AW-1:0] a, input bit slp);
    strb_cpu_n = pn; strb_ctl_n = cn; adv_n = an; ce_n = c1n; ce2_n = c2n; ce3 = c3;
    gw_n = gwn; bw_en_n = bwn; lane_n = ln; wdata_i = wd; addr_i = a; sleep_i = slp;
    model_step();
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle(input string tag);
    cyc(tag, 1, 1, 1, 0, 0, 1, 1, 1, 4'hF, '0, '0, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13: reset state
    check("R13");
    rst_n = 1'b1;
    @(negedge clk);
    check("R13");

    // R4, R6: controller-strobe global writes fill every word in bursts
    for (int b = 0; b < DEPTH; b += 4) begin
      cyc("R4", 1, 0, 1, 0, 0, 1, 0, 1, 4'hF, word_of(b), AW'(b), 0);
      for (int k = 1; k < 4; k++)
        cyc("R6", 1, 1, 0, 0, 0, 1, 0, 1, 4'hF, word_of(b + k), '0, 0);
    end

    // R5: load with secondary enable inactive deselects
    cyc("R5", 1, 0, 1, 0, 1, 1, 1, 1, 4'hF, '0, 8'd9, 0);
    idle("R5");
    // R9, R1: first read after deselect is undriven; write enables ignored on processor load
    cyc("R9", 0, 1, 1, 0, 0, 1, 0, 0, 4'h0, 36'hF_FFFF_FFFF, 8'd5, 0);
    // R8, R11: advance returns next word (exclusive-or order)
    cyc("R8", 1, 1, 0, 0, 0, 1, 1, 1, 4'hF, '0, '0, 0);
    cyc("R8", 1, 1, 1, 0, 0, 1, 1, 1, 4'hF, '0, '0, 0);
    cyc("R11", 1, 1, 0, 0, 0, 1, 1, 1, 4'hF, '0, '0, 0);
    cyc("R11", 1, 1, 0, 0, 0, 1, 1, 1, 4'hF, '0, '0, 0);
    cyc("R11", 1, 1, 0, 0, 0, 1, 1, 1, 4'hF, '0, '0, 0);
    // R1: the ignored write left address 5 intact
    cyc("R1", 1, 0, 1, 0, 0, 1, 1, 1, 4'hF, '0, 8'd5, 0);
    cyc("R1", 1, 1, 1, 0, 0, 1, 1, 1, 4'hF, '0, '0, 0);

    // R2, R7: processor load then lane-masked write to the loaded address
    cyc("R2", 0, 1, 1, 0, 0, 1, 1, 1, 4'hF, '0, 8'd22, 0);
    cyc("R7", 1, 1, 1, 0, 0, 1, 1, 0, 4'b1010, 36'h1_2345_6789, '0, 0);
    cyc("R7", 1, 1, 1, 0, 0, 1, 1, 1, 4'hF, '0, '0, 0);
    cyc("R7", 1, 1, 1, 0, 0, 1, 1, 1, 4'hF, '0, '0, 0);
    // R6: byte-write enable high disables lane enables
    cyc("R6", 1, 0, 1, 0, 0, 1, 1, 1, 4'h0, 36'h0, 8'd22, 0);
    cyc("R6", 1, 1, 1, 0, 0, 1, 1, 1, 4'hF, '0, '0, 0);

    // R3: processor strobe with primary enable high is ignored (continue cycle)
    cyc("R3", 0, 1, 0, 1, 0, 1, 1, 1, 4'hF, '0, 8'd200, 0);
    cyc("R3", 0, 1, 1, 1, 0, 1, 1, 1, 4'hF, '0, 8'd201, 0);
    // R3: with primary enable high, a controller strobe deselects
    cyc("R3", 0, 0, 1, 1, 0, 1, 1, 1, 4'hF, '0, 8'd40, 0);
    idle("R3");

    // R12: both strobes with global write: processor read wins, no write
    cyc("R12", 0, 0, 1, 0, 0, 1, 1, 1, 4'hF, '0, 8'd60, 0);
    cyc("R12", 0, 0, 1, 0, 0, 1, 0, 1, 4'hF, 36'h0_0000_0000, 8'd61, 0);
    cyc("R12", 1, 0, 1, 0, 0, 1, 1, 1, 4'hF, '0, 8'd61, 0);
    cyc("R12", 1, 1, 1, 0, 0, 1, 1, 1, 4'hF, '0, '0, 0);

    // R10: sleep ignores strobes and writes, data kept, access needs a new strobe
    cyc("R10", 1, 0, 0, 0, 0, 1, 0, 1, 4'hF, 36'h0, 8'd61, 1);
    cyc("R10", 0, 1, 0, 0, 0, 1, 0, 1, 4'hF, 36'h0, 8'd62, 1);
    cyc("R10", 1, 1, 0, 0, 0, 1, 1, 1, 4'hF, '0, '0, 0);
    cyc("R10", 1, 1, 1, 0, 0, 1, 0, 1, 4'hF, 36'h0, '0, 0);
    cyc("R10", 1, 0, 1, 0, 0, 1, 1, 1, 4'hF, '0, 8'd61, 0);
    cyc("R10", 1, 1, 0, 0, 0, 1, 1, 1, 4'hF, '0, '0, 0);
    cyc("R10", 1, 1, 1, 0, 0, 1, 1, 1, 4'hF, '0, '0, 0);

    // R11: ascending order from start offset 2 wraps within the group
    lin_mode_i = 1'b1;
    cyc("R11", 1, 0, 1, 0, 0, 1, 1, 1, 4'hF, '0, 8'd130, 0);
    for (int k = 0; k < 5; k++) cyc("R11", 1, 1, 0, 0, 0, 1, 1, 1, 4'hF, '0, '0, 0);
    lin_mode_i = 1'b0;

    // Random mix over all functions (R1-R13 rules all applied by the model)
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 4000; i++) begin
      if (i % 500 == 0) lin_mode_i = $urandom_range(0, 1);
      cyc("R8", ($urandom_range(0, 99) >= 15), ($urandom_range(0, 99) >= 20),
          $urandom_range(0, 1), ($urandom_range(0, 99) < 8), ($urandom_range(0, 99) < 5),
          ($urandom_range(0, 99) >= 5), ($urandom_range(0, 99) >= 10),
          ($urandom_range(0, 99) >= 40), 4'($urandom_range(0, 15)),
          {4'($urandom), 32'($urandom)}, AW'($urandom), ($urandom_range(0, 99) < 3));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule